// File: doc/BRIEF.md
# Double-Buffered Mailbox Page Controller

This block keeps track of which half of a ping-pong shared memory is live for each direction of a controller/signal-processor mailbox. One bit selects the write page (controller to processor) and another selects the read page (processor to controller). At every frame strobe the block latches the base address of each live page onto its outputs and then scrubs the live write page through a one-word-per-cycle memory write port. If the read page was consumed since the previous frame, the block also scrubs that page. It then stores a status word marking "synchronisation result not found" into the page, and flips the read page bit so the processor fills the other half next.

An abort command returns everything to page zero at once. It drops queued and in-flight work. It then writes the no-task code into the four task words of write page zero and sets the task-abort bit in that page's system control word. Frame strobes that arrive while a scrub is running are counted and served in order, up to a queue depth parameter. The write page bit is flipped by a separate swap pulse from the side that owns the write buffer.

Top module: `mbx_page_ctrl`

## Requirements
- R1: After synchronous reset both page bits are 0, the used flag is clear, `busy_o` and `mem_we_o` are 0, `wr_base_o` equals `W0_BASE` and `rd_base_o` equals `R0_BASE`.
- R2: When a frame job starts, `wr_base_o` takes `W0_BASE` or `W1_BASE` and `rd_base_o` takes `R0_BASE` or `R1_BASE`, chosen by the page bits at that moment (bit value 1 selects the `*1_BASE`).
- R3: Every frame job first writes 0 to all `PAGE_WORDS` words of the write page. The addresses run from `wr_base_o` upward, one per cycle, and the first write comes in the cycle after the strobe is accepted.
- R4: If the used flag was set when the job started, the job then writes 0 to every word of the read page in ascending order. Next it writes a word with only bit `CRC_BIT` set (value 4 by default) to `rd_base_o + SYNC_OFS`, and after that the read page bit inverts.
- R5: If the used flag was clear when the job started, the job makes no read-page writes and the read page bit is unchanged.
- R6: A `rd_used_i` pulse sets the used flag, and the flag is cleared when a job starts. A pulse that arrives during a job counts toward the next job, and a pulse in the same cycle as the starting strobe counts toward that job.
- R7: A strobe that arrives while a job runs or strobes are pending is queued, up to `QDEPTH` strobes; further strobes are dropped. Queued jobs run in arrival order, and `busy_o` stays high while a job runs or any strobe is pending.
- R8: `abort_i` clears both page bits, the used flag and the queue, and cancels any job in progress. From the next cycle the bases read `W0_BASE` and `R0_BASE`. Abort wins over a strobe or a swap in the same cycle.
- R9: After an abort the block writes 0 (the no-task code) to offsets 0, 1, 2 and 3 of write page zero in that order. It then writes a word with only bit `ABORT_BIT` set (value 2 by default) to `W0_BASE + CTRL_OFS`.
- R10: A `wr_swap_i` pulse inverts the write page bit. The new value is used from the next job start onward.
- R11: `mem_we_o` is high only while `busy_o` is high, and every write falls inside one of the four pages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_i | input | 1 | Frame strobe, one cycle per frame |
| rd_used_i | input | 1 | Pulse: the read page was consumed this frame |
| abort_i | input | 1 | Abort command pulse |
| wr_swap_i | input | 1 | Pulse: invert the write page bit |
| mem_we_o | output | 1 | Shared-memory write enable |
| mem_addr_o | output | 16 | Shared-memory word address |
| mem_wdata_o | output | 16 | Shared-memory write data |
| wr_page_o | output | 1 | Current write page bit |
| rd_page_o | output | 1 | Current read page bit |
| wr_base_o | output | 16 | Base address of the live write page |
| rd_base_o | output | 16 | Base address of the live read page |
| busy_o | output | 1 | Job running or strobes pending |

## Verification
A wrong page bit or a stale used flag shows at the ports one frame later. The next job scrubs the wrong base or leaves out the read scrub and the status word, so it appears as a wrong address or a missing write within a page's worth of cycles. A faulty queue count shows as one job too many or too few at the memory port. A faulty abort shows as nonzero pages or bases one cycle after the command and as wrong task/control writes during the next five cycles. The bench compares every memory write in order against an arithmetic model over all used/swap patterns of four consecutive frames.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int unsigned MBX_AW       = 16;
    localparam int unsigned MBX_DW       = 16;
    localparam int unsigned N_TASK_WORDS = 4;

    typedef logic [MBX_AW-1:0] addr_t;
    typedef logic [MBX_DW-1:0] word_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_WCLR,
        SQ_RCLR,
        SQ_STAT,
        SQ_ABT
    } seq_e;

    typedef struct packed {
        logic  we;
        addr_t addr;
        word_t data;
    } mem_wr_t;

    function automatic addr_t pick_base(input logic sel, input addr_t b0, input addr_t b1);
        return sel ? b1 : b0;
    endfunction

    function automatic word_t bit_word(input int unsigned pos);
        return word_t'(1) << pos;
    endfunction

endpackage

// File: rtl/mbx_frame_queue.sv
module mbx_frame_queue #(
    parameter int unsigned QDEPTH = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_i,
    input  logic abort_i,
    input  logic seq_idle_i,
    output logic start_o,
    output logic pending_o
);
    localparam int unsigned CW = $clog2(QDEPTH + 1);

    logic [CW-1:0] cnt;

    assign pending_o = (cnt != '0);
    assign start_o   = seq_idle_i && !abort_i && (pending_o || frame_i);

    always_ff @(posedge clk) begin
        if (rst || abort_i) begin
            cnt <= '0;
        end else if (start_o && pending_o && !frame_i) begin
            cnt <= cnt - 1'b1;
        end else if (!start_o && frame_i && (cnt != CW'(QDEPTH))) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mbx_page_state.sv
module mbx_page_state
    import mbx_pkg::*;
#(
    parameter addr_t W0_BASE = 16'h0100,
    parameter addr_t W1_BASE = 16'h0180,
    parameter addr_t R0_BASE = 16'h0200,
    parameter addr_t R1_BASE = 16'h0280
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start_i,
    input  logic  abort_i,
    input  logic  wr_swap_i,
    input  logic  rd_used_i,
    input  logic  rd_toggle_i,
    output logic  wr_page_o,
    output logic  rd_page_o,
    output addr_t wr_base_o,
    output addr_t rd_base_o,
    output logic  used_snap_o
);
    logic used_q;

    always_ff @(posedge clk) begin
        if (rst || abort_i) begin
            wr_page_o   <= 1'b0;
            rd_page_o   <= 1'b0;
            used_q      <= 1'b0;
            used_snap_o <= 1'b0;
            wr_base_o   <= W0_BASE;
            rd_base_o   <= R0_BASE;
        end else begin
            if (wr_swap_i) begin
                wr_page_o <= ~wr_page_o;
            end
            if (rd_toggle_i) begin
                rd_page_o <= ~rd_page_o;
            end
            if (start_i) begin
                wr_base_o   <= pick_base(wr_page_o, W0_BASE, W1_BASE);
                rd_base_o   <= pick_base(rd_page_o, R0_BASE, R1_BASE);
                used_snap_o <= used_q | rd_used_i;
                used_q      <= 1'b0;
            end else begin
                used_q <= used_q | rd_used_i;
            end
        end
    end
endmodule

// File: rtl/mbx_clear_seq.sv
module mbx_clear_seq
    import mbx_pkg::*;
#(
    parameter int unsigned PAGE_WORDS = 8,
    parameter int unsigned SYNC_OFS   = 2,
    parameter int unsigned CRC_BIT    = 2,
    parameter int unsigned CTRL_OFS   = 4,
    parameter int unsigned ABORT_BIT  = 1,
    parameter addr_t       W0_BASE    = 16'h0100
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start_i,
    input  logic    abort_i,
    input  logic    used_snap_i,
    input  addr_t   wr_base_i,
    input  addr_t   rd_base_i,
    output mem_wr_t mem_o,
    output logic    rd_toggle_o,
    output logic    idle_o
);
    localparam int unsigned SEQ_LEN = (PAGE_WORDS > N_TASK_WORDS + 1) ? PAGE_WORDS : N_TASK_WORDS + 1;
    localparam int unsigned IW      = $clog2(SEQ_LEN);

    seq_e          state;
    logic [IW-1:0] idx;
    logic          last_page;
    logic          last_abt;

    assign last_page   = (idx == IW'(PAGE_WORDS - 1));
    assign last_abt    = (idx == IW'(N_TASK_WORDS));
    assign idle_o      = (state == SQ_IDLE);
    assign rd_toggle_o = (state == SQ_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            idx   <= '0;
        end else if (abort_i) begin
            state <= SQ_ABT;
            idx   <= '0;
        end else begin
            unique case (state)
                SQ_IDLE: begin
                    idx <= '0;
                    if (start_i) begin
                        state <= SQ_WCLR;
                    end
                end
                SQ_WCLR: begin
                    if (last_page) begin
                        idx   <= '0;
                        state <= used_snap_i ? SQ_RCLR : SQ_IDLE;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                SQ_RCLR: begin
                    if (last_page) begin
                        idx   <= '0;
                        state <= SQ_STAT;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                SQ_STAT: begin
                    state <= SQ_IDLE;
                end
                SQ_ABT: begin
                    if (last_abt) begin
                        idx   <= '0;
                        state <= SQ_IDLE;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_o = '0;
        unique case (state)
            SQ_WCLR: begin
                mem_o.we   = 1'b1;
                mem_o.addr = wr_base_i + addr_t'(idx);
            end
            SQ_RCLR: begin
                mem_o.we   = 1'b1;
                mem_o.addr = rd_base_i + addr_t'(idx);
            end
            SQ_STAT: begin
                mem_o.we   = 1'b1;
                mem_o.addr = rd_base_i + addr_t'(SYNC_OFS);
                mem_o.data = bit_word(CRC_BIT);
            end
            SQ_ABT: begin
                mem_o.we = 1'b1;
                if (last_abt) begin
                    mem_o.addr = W0_BASE + addr_t'(CTRL_OFS);
                    mem_o.data = bit_word(ABORT_BIT);
                end else begin
                    mem_o.addr = W0_BASE + addr_t'(idx);
                end
            end
            default: mem_o = '0;
        endcase
    end
endmodule

// File: rtl/mbx_page_ctrl.sv
module mbx_page_ctrl
    import mbx_pkg::*;
#(
    parameter int unsigned PAGE_WORDS = 8,
    parameter int unsigned QDEPTH     = 3,
    parameter int unsigned SYNC_OFS   = 2,
    parameter int unsigned CRC_BIT    = 2,
    parameter int unsigned CTRL_OFS   = 4,
    parameter int unsigned ABORT_BIT  = 1,
    parameter addr_t       W0_BASE    = 16'h0100,
    parameter addr_t       W1_BASE    = 16'h0180,
    parameter addr_t       R0_BASE    = 16'h0200,
    parameter addr_t       R1_BASE    = 16'h0280
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_i,
    input  logic              rd_used_i,
    input  logic              abort_i,
    input  logic              wr_swap_i,
    output logic              mem_we_o,
    output logic [MBX_AW-1:0] mem_addr_o,
    output logic [MBX_DW-1:0] mem_wdata_o,
    output logic              wr_page_o,
    output logic              rd_page_o,
    output logic [MBX_AW-1:0] wr_base_o,
    output logic [MBX_AW-1:0] rd_base_o,
    output logic              busy_o
);
    logic    seq_idle;
    logic    job_start;
    logic    pending;
    logic    used_snap;
    logic    rd_toggle;
    mem_wr_t mem_wr;

    mbx_frame_queue #(.QDEPTH(QDEPTH)) u_queue (
        .clk        (clk),
        .rst        (rst),
        .frame_i    (frame_i),
        .abort_i    (abort_i),
        .seq_idle_i (seq_idle),
        .start_o    (job_start),
        .pending_o  (pending)
    );

    mbx_page_state #(
        .W0_BASE (W0_BASE),
        .W1_BASE (W1_BASE),
        .R0_BASE (R0_BASE),
        .R1_BASE (R1_BASE)
    ) u_state (
        .clk         (clk),
        .rst         (rst),
        .start_i     (job_start),
        .abort_i     (abort_i),
        .wr_swap_i   (wr_swap_i),
        .rd_used_i   (rd_used_i),
        .rd_toggle_i (rd_toggle),
        .wr_page_o   (wr_page_o),
        .rd_page_o   (rd_page_o),
        .wr_base_o   (wr_base_o),
        .rd_base_o   (rd_base_o),
        .used_snap_o (used_snap)
    );

    mbx_clear_seq #(
        .PAGE_WORDS (PAGE_WORDS),
        .SYNC_OFS   (SYNC_OFS),
        .CRC_BIT    (CRC_BIT),
        .CTRL_OFS   (CTRL_OFS),
        .ABORT_BIT  (ABORT_BIT),
        .W0_BASE    (W0_BASE)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (job_start),
        .abort_i     (abort_i),
        .used_snap_i (used_snap),
        .wr_base_i   (wr_base_o),
        .rd_base_i   (rd_base_o),
        .mem_o       (mem_wr),
        .rd_toggle_o (rd_toggle),
        .idle_o      (seq_idle)
    );

    assign mem_we_o    = mem_wr.we;
    assign mem_addr_o  = mem_wr.addr;
    assign mem_wdata_o = mem_wr.data;
    assign busy_o      = !seq_idle || pending;
endmodule

// File: rtl/mbx_page_ctrl_chk.sv
module mbx_page_ctrl_chk
    import mbx_pkg::*;
#(
    parameter int unsigned PAGE_WORDS = 8,
    parameter int unsigned CRC_BIT    = 2,
    parameter addr_t       W0_BASE    = 16'h0100,
    parameter addr_t       W1_BASE    = 16'h0180,
    parameter addr_t       R0_BASE    = 16'h0200,
    parameter addr_t       R1_BASE    = 16'h0280
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_i,
    input logic              abort_i,
    input logic              mem_we_o,
    input logic [MBX_AW-1:0] mem_addr_o,
    input logic [MBX_DW-1:0] mem_wdata_o,
    input logic              wr_page_o,
    input logic              rd_page_o,
    input logic [MBX_AW-1:0] wr_base_o,
    input logic [MBX_AW-1:0] rd_base_o,
    input logic              busy_o
);
    logic in_page;
    assign in_page = (addr_t'(mem_addr_o - W0_BASE) < addr_t'(PAGE_WORDS)) ||
                     (addr_t'(mem_addr_o - W1_BASE) < addr_t'(PAGE_WORDS)) ||
                     (addr_t'(mem_addr_o - R0_BASE) < addr_t'(PAGE_WORDS)) ||
                     (addr_t'(mem_addr_o - R1_BASE) < addr_t'(PAGE_WORDS));

    p_write_when_busy_r11: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> busy_o);

    p_write_in_page_r11: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> in_page);

    p_toggle_after_status_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_page_o != $past(rd_page_o)) && !$past(abort_i) && !$past(rst)
        |-> $past(mem_we_o) && ($past(mem_wdata_o) == bit_word(CRC_BIT)));

    p_abort_home_r8: assert property (@(posedge clk) disable iff (rst)
        abort_i |=> !wr_page_o && !rd_page_o && (wr_base_o == W0_BASE) && (rd_base_o == R0_BASE));

    p_strobe_starts_r3: assert property (@(posedge clk) disable iff (rst)
        frame_i && !busy_o && !abort_i |=> busy_o && mem_we_o);
endmodule

bind mbx_page_ctrl mbx_page_ctrl_chk #(
    .PAGE_WORDS (PAGE_WORDS),
    .CRC_BIT    (CRC_BIT),
    .W0_BASE    (W0_BASE),
    .W1_BASE    (W1_BASE),
    .R0_BASE    (R0_BASE),
    .R1_BASE    (R1_BASE)
) u_chk (.*);

// File: tb/tb_mbx_page_ctrl.sv
module tb_mbx_page_ctrl;
    localparam int          PW   = 8;
    localparam logic [15:0] W0   = 16'h0100;
    localparam logic [15:0] W1   = 16'h0180;
    localparam logic [15:0] R0   = 16'h0200;
    localparam logic [15:0] R1   = 16'h0280;
    localparam logic [15:0] STAT = 16'h0004;
    localparam logic [15:0] ABTW = 16'h0002;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_i = 1'b0, rd_used_i = 1'b0, abort_i = 1'b0, wr_swap_i = 1'b0;
    logic        mem_we_o, wr_page_o, rd_page_o, busy_o;
    logic [15:0] mem_addr_o, mem_wdata_o, wr_base_o, rd_base_o;

    mbx_page_ctrl dut (.*);

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    logic [31:0] expq[$];
    logic m_wr = 1'b0, m_rd = 1'b0, m_used = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory port monitor: every write must match the model, in order (R3 R4 R9 R11)
    always @(negedge clk) begin
        if (!rst && mem_we_o) begin
            chk(busy_o, "R11 write while idle", 0, 1);
            if (expq.size() == 0) begin
                chk(1'b0, "R3/R4 unexpected write", {mem_addr_o, mem_wdata_o}, 0);
            end else begin
                logic [31:0] e;
                e = expq.pop_front();
                chk({mem_addr_o, mem_wdata_o} == e, "R3/R4/R9 write addr_data",
                    {mem_addr_o, mem_wdata_o}, e);
            end
        end
    end

    function automatic void model_job();
        logic [15:0] wb, rb;
        wb = m_wr ? W1 : W0;
        rb = m_rd ? R1 : R0;
        for (int i = 0; i < PW; i++) expq.push_back({wb + 16'(i), 16'h0});
        if (m_used) begin
            for (int i = 0; i < PW; i++) expq.push_back({rb + 16'(i), 16'h0});
            expq.push_back({rb + 16'd2, STAT});
            m_rd = ~m_rd;
        end
        m_used = 1'b0;
    endfunction

    function automatic void model_abort();
        for (int i = 0; i < 4; i++) expq.push_back({W0 + 16'(i), 16'h0});
        expq.push_back({W0 + 16'd4, ABTW});
        m_wr = 1'b0; m_rd = 1'b0; m_used = 1'b0;
    endfunction

    task automatic pulse_frame();
        @(posedge clk); #1 frame_i = 1'b1;
        @(posedge clk); #1 frame_i = 1'b0;
    endtask
    task automatic pulse_used();
        @(posedge clk); #1 rd_used_i = 1'b1;
        @(posedge clk); #1 rd_used_i = 1'b0;
    endtask
    task automatic pulse_swap();
        @(posedge clk); #1 wr_swap_i = 1'b1;
        @(posedge clk); #1 wr_swap_i = 1'b0;
    endtask
    task automatic wait_idle();
        int n = 0;
        @(negedge clk);
        while (busy_o && n < 500) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
    endtask
    task automatic chk_pages(input string req);
        chk(wr_page_o == m_wr, {req, " wr_page"}, wr_page_o, m_wr);
        chk(rd_page_o == m_rd, {req, " rd_page"}, rd_page_o, m_rd);
        chk(expq.size() == 0, {req, " writes outstanding"}, expq.size(), 0);
    endtask

    initial begin
        #1_000_000;
        chk(1'b0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!busy_o && !mem_we_o, "R1 busy/we", {busy_o, mem_we_o}, 0);
        chk(!wr_page_o && !rd_page_o, "R1 pages", {wr_page_o, rd_page_o}, 0);
        chk(wr_base_o == W0, "R1 wr_base", wr_base_o, W0);
        chk(rd_base_o == R0, "R1 rd_base", rd_base_o, R0);

        // R3 / R5: frame with no use
        model_job();
        pulse_frame();
        @(negedge clk);
        chk(mem_we_o == 1'b1, "R3 first write one cycle after strobe", mem_we_o, 1);
        wait_idle();
        chk_pages("R5");

        // R4: used page scrubbed, status preset, toggled; R2 base follows
        m_used = 1'b1;
        pulse_used();
        model_job();
        pulse_frame();
        wait_idle();
        chk_pages("R4");
        model_job();
        pulse_frame();
        wait_idle();
        chk(rd_base_o == R1, "R2 rd_base after toggle", rd_base_o, R1);
        chk_pages("R2");

        // Sweep: all swap/use patterns over four consecutive frames (R2 R4 R5 R10)
        for (int p = 0; p < 256; p++) begin
            for (int f = 0; f < 4; f++) begin
                if (p[2*f]) begin m_wr = ~m_wr; pulse_swap(); end
                if (p[2*f+1]) begin m_used = 1'b1; pulse_used(); end
                begin
                    logic ew, er;
                    ew = m_wr; er = m_rd;
                    model_job();
                    pulse_frame();
                    wait_idle();
                    chk(wr_base_o == (ew ? W1 : W0), "R2/R10 wr_base", wr_base_o, ew ? W1 : W0);
                    chk(rd_base_o == (er ? R1 : R0), "R2 rd_base", rd_base_o, er ? R1 : R0);
                end
                chk_pages("R10 sweep");
            end
        end

        // R6: use pulse during a job counts for the next job
        model_job();
        pulse_frame();
        pulse_used();
        m_used = 1'b1;
        wait_idle();
        chk_pages("R6 current job");
        model_job();
        pulse_frame();
        wait_idle();
        chk_pages("R6 next job");

        // R7: five strobes while busy, depth 3 keeps three
        model_job(); model_job(); model_job(); model_job();
        pulse_frame();
        for (int k = 0; k < 4; k++) pulse_frame();
        @(negedge clk);
        chk(busy_o == 1'b1, "R7 busy while queued", busy_o, 1);
        wait_idle();
        chk_pages("R7 queue");

        // R8/R9: abort mid-job with a queued strobe
        m_wr = ~m_wr; pulse_swap();
        m_used = 1'b1; pulse_used();
        model_job();
        pulse_frame();
        m_rd = ~m_rd;
        for (int i = 0; i < PW; i++) void'(expq.pop_back());
        void'(expq.pop_back());
        for (int i = 0; i < PW - 3; i++) void'(expq.pop_back());
        // three write-page words remain expected, then frame queued and aborted
        @(posedge clk); #1 frame_i = 1'b1;
        @(posedge clk); #1 frame_i = 1'b0; abort_i = 1'b1;
        model_abort();
        @(posedge clk); #1 abort_i = 1'b0;
        @(negedge clk);
        chk(!wr_page_o && !rd_page_o, "R8 pages after abort", {wr_page_o, rd_page_o}, 0);
        chk(wr_base_o == W0 && rd_base_o == R0, "R8 bases after abort", {wr_base_o, rd_base_o}, {W0, R0});
        wait_idle();
        chk_pages("R9 abort words");

        // R9: abort while idle; R8 used flag cleared by abort
        pulse_used();
        @(posedge clk); #1 abort_i = 1'b1;
        model_abort();
        @(posedge clk); #1 abort_i = 1'b0;
        wait_idle();
        model_job();
        pulse_frame();
        wait_idle();
        chk_pages("R8 used cleared");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule